// File: doc/BRIEF.md
# Universal Shift Register with Bidirectional Parallel Bus

This block is a parameterized register (eight bits by default) that can keep its value, move its contents one place toward the high end, move them one place toward the low end, or capture a whole word at once. A two-bit mode input selects the operation, and every change happens on the rising clock edge. An active-low asynchronous reset clears the register and overrides both the clock and the mode.

The parallel side is a single bidirectional bus. When both active-low output enables are low and the block is not in load mode, it drives its register contents onto the bus. In every other case it releases the bus to high impedance, so another agent can drive it. Load mode releases the bus by itself so that the word to be captured can be presented on the same wires. The register keeps working while the bus is released.

Two serial inputs feed the two shift directions. Two serial outputs, always driven, carry the lowest and highest bits. Chaining these between instances builds longer shift words.

Top module: `ushift_bus`

## Requirements
- R1: A low level on `rst_n` clears every register bit at once, without waiting for a clock edge. While `rst_n` stays low, the register stays zero whatever the mode and clock do.
- R2: With `mode_sel` = 2'b00 (hold), a rising clock edge leaves the register unchanged.
- R3: With `mode_sel` = 2'b01 (shift up), each rising edge moves bit n into bit n+1 and loads `ser_up_in` into bit 0.
- R4: With `mode_sel` = 2'b10 (shift down), each rising edge moves bit n into bit n-1 and loads `ser_down_in` into the top bit.
- R5: With `mode_sel` = 2'b11 (load), each rising edge copies the value present on `bus_io` into the register.
- R6: When `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11, `bus_io` carries the register contents, bit i on `bus_io[i]`.
- R7: When `oe_a_n` or `oe_b_n` is 1, the block does not drive `bus_io`: a bus with pull-ups reads all ones.
- R8: When `mode_sel` is 2'b11, the block does not drive `bus_io`, whatever the output enables are.
- R9: `ser_lo_out` always equals register bit 0 and `ser_hi_out` always equals the top bit, whatever the mode and output enables.
- R10: Hold, both shifts, load and reset behave as in R1 to R5 while the bus is released by the output enables.
- R11: Two instances chained as one word behave as a single register of twice the width. In the chain, the lower instance's `ser_hi_out` feeds the upper instance's `ser_up_in`, and the upper instance's `ser_lo_out` feeds the lower instance's `ser_down_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Second bus output enable, active low |
| ser_up_in | input | 1 | Bit entering bit 0 when shifting up |
| ser_down_in | input | 1 | Bit entering the top bit when shifting down |
| bus_io | inout | WIDTH | Parallel bus: register output when driven, load input in load mode |
| ser_lo_out | output | 1 | Register bit 0 |
| ser_hi_out | output | 1 | Register top bit |

## Verification
A wrong internal bit reaches the ports within the same cycle through one of two paths. The serial outputs expose the two end bits at all times. The bus exposes the whole word whenever the block drives it. The bench therefore reads the full word back after every clock edge, using a hold cycle with the enables low, so a fault in a shift, load or hold is reported on the first edge where it occurs. A fault in the enable logic shows at once as a released bus that reads anything other than all ones through the pull-ups, or as a driven bus that does not match the model. Chaining two instances shows whether the end bits cross between neighbours on the same edge.

// File: rtl/ushift_pkg.sv
`timescale 1ns/1ps
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } ushift_mode_e;

    typedef struct packed {
        logic hold;
        logic up;
        logic down;
        logic load;
    } ushift_ctl_t;

endpackage

// File: rtl/ushift_decode.sv
`timescale 1ns/1ps
module ushift_decode
    import ushift_pkg::*;
(
    input  logic [1:0]  mode_sel,
    input  logic        oe_a_n,
    input  logic        oe_b_n,
    output ushift_ctl_t ctl,
    output logic        drive_en
);
    ushift_mode_e mode;

    assign mode = ushift_mode_e'(mode_sel);

    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_HOLD: ctl.hold = 1'b1;
            MODE_UP:   ctl.up   = 1'b1;
            MODE_DOWN: ctl.down = 1'b1;
            MODE_LOAD: ctl.load = 1'b1;
            default:   ctl.hold = 1'b1;
        endcase
    end

    // Both enables must be asserted; load mode always frees the bus.
    always_comb begin
        drive_en = ~oe_a_n & ~oe_b_n & ~ctl.load;
    end
endmodule

// File: rtl/ushift_core.sv
`timescale 1ns/1ps
module ushift_core
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ushift_ctl_t      ctl,
    input  logic             ser_up_in,
    input  logic             ser_down_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] data_q
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } core_st_t;

    core_st_t st_d;
    core_st_t st_q;

    logic [WIDTH-1:0] from_below;
    logic [WIDTH-1:0] from_above;

    // Neighbour taps per bit; the end bits take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (i == 0) begin : g_low_end
            assign from_below[i] = ser_up_in;
        end else begin : g_low_mid
            assign from_below[i] = st_q.data[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign from_above[i] = ser_down_in;
        end else begin : g_high_mid
            assign from_above[i] = st_q.data[i+1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (ctl.load) begin
            st_d.data = par_in;
        end else if (ctl.up) begin
            st_d.data = from_below;
        end else if (ctl.down) begin
            st_d.data = from_above;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;
endmodule

// File: rtl/ushift_bus.sv
`timescale 1ns/1ps
module ushift_bus
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_up_in,
    input  logic             ser_down_in,
    inout  wire  [WIDTH-1:0] bus_io,
    output logic             ser_lo_out,
    output logic             ser_hi_out
);
    localparam int TOP = WIDTH - 1;

    ushift_ctl_t      ctl;
    logic             drive_en;
    logic [WIDTH-1:0] data_q;

    ushift_decode u_decode (
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .ctl      (ctl),
        .drive_en (drive_en)
    );

    ushift_core #(.WIDTH(WIDTH)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .ser_up_in   (ser_up_in),
        .ser_down_in (ser_down_in),
        .par_in      (bus_io),
        .data_q      (data_q)
    );

    assign bus_io     = drive_en ? data_q : {WIDTH{1'bz}};
    assign ser_lo_out = data_q[0];
    assign ser_hi_out = data_q[TOP];
endmodule

// File: rtl/ushift_bus_chk.sv
`timescale 1ns/1ps
module ushift_bus_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_up_in,
    input logic             ser_down_in,
    input logic [WIDTH-1:0] bus_io,
    input logic             ser_lo_out,
    input logic [WIDTH-1:0] data_q
);
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b00 |=> data_q == $past(data_q)); // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b01 |=> data_q == {$past(data_q[WIDTH-2:0]), $past(ser_up_in)}); // R3

    AST_SHIFT_UP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b01 |=> ser_lo_out == $past(ser_up_in)); // R9

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b10 |=> data_q == {$past(ser_down_in), $past(data_q[WIDTH-1:1])}); // R4

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b11 |=> data_q == $past(bus_io)); // R5

    AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> bus_io == data_q); // R6
endmodule

bind ushift_bus ushift_bus_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .oe_a_n      (oe_a_n),
    .oe_b_n      (oe_b_n),
    .ser_up_in   (ser_up_in),
    .ser_down_in (ser_down_in),
    .bus_io      (bus_io),
    .ser_lo_out  (ser_lo_out),
    .data_q      (data_q)
);

// File: tb/ushift_bus_bench.sv
`timescale 1ns/1ps
module ushift_bus_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic [1:0] mode = 2'b00;
    logic oe_a = 1'b0, oe_b = 1'b0, oe_hi = 1'b0;
    logic s_up = 1'b0, s_dn = 1'b0, s_dn_hi = 1'b0;
    logic casc = 1'b0;
    logic [W-1:0] drv_lo = '0, drv_hi = '0;
    logic [W-1:0] mdl_lo = '0, mdl_hi = '0;
    logic done = 1'b0;
    int n_chk = 0, n_fail = 0;
    string last_req = "R1";

    wire [W-1:0] bus_lo, bus_hi;
    wire lo_lsb, lo_msb, hi_lsb, hi_msb;
    wire lo_dn_in = casc ? hi_lsb : s_dn;

    always #5 clk = ~clk;

    for (genvar i = 0; i < W; i++) begin : g_pull
        pullup (bus_lo[i]);
        pullup (bus_hi[i]);
    end

    assign bus_lo = (mode == 2'b11) ? drv_lo : {W{1'bz}};
    assign bus_hi = (mode == 2'b11) ? drv_hi : {W{1'bz}};

    ushift_bus #(.WIDTH(W)) u_ushift_bus (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(oe_a), .oe_b_n(oe_b),
        .ser_up_in(s_up), .ser_down_in(lo_dn_in), .bus_io(bus_lo),
        .ser_lo_out(lo_lsb), .ser_hi_out(lo_msb)
    );

    ushift_bus #(.WIDTH(W)) u_ushift_bus_hi (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(oe_hi), .oe_b_n(1'b0),
        .ser_up_in(lo_msb), .ser_down_in(s_dn_hi), .bus_io(bus_hi),
        .ser_lo_out(hi_lsb), .ser_hi_out(hi_msb)
    );

    function automatic logic [W-1:0] next_val(input logic [W-1:0] cur, input logic [1:0] m,
                                              input logic up_bit, input logic dn_bit,
                                              input logic [W-1:0] par);
        case (m)
            2'b01:   return {cur[W-2:0], up_bit};
            2'b10:   return {dn_bit, cur[W-1:1]};
            2'b11:   return par;
            default: return cur;
        endcase
    endfunction

    function automatic logic [W-1:0] bus_expect(input logic [W-1:0] st, input logic [1:0] m,
                                                input logic oe_released, input logic [W-1:0] par);
        if (m == 2'b11) return par;
        if (oe_released) return {W{1'b1}};
        return st;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; ends just after the next falling edge.
    task automatic step(input logic [1:0] m, input logic a, input logic b, input logic ahi,
                        input logic up, input logic dn, input logic dnhi,
                        input logic [W-1:0] plo, input logic [W-1:0] phi, input string req);
        logic dn_eff;
        // full readback of both registers through a hold cycle with the bus driven
        mode = 2'b00; oe_a = 1'b0; oe_b = 1'b0; oe_hi = 1'b0;
        #1;
        check({last_req, " readback lo (R6)"}, bus_lo, mdl_lo);
        check({last_req, " readback hi (R11)"}, bus_hi, mdl_hi);
        mode = m; oe_a = a; oe_b = b; oe_hi = ahi;
        s_up = up; s_dn = dn; s_dn_hi = dnhi; drv_lo = plo; drv_hi = phi;
        #1;
        check((m == 2'b11) ? "R8 bus lo" : ((a | b) ? "R7 bus lo" : "R6 bus lo"),
              bus_lo, bus_expect(mdl_lo, m, a | b, plo));
        check((m == 2'b11) ? "R8 bus hi" : (ahi ? "R7 bus hi" : "R6 bus hi"),
              bus_hi, bus_expect(mdl_hi, m, ahi, phi));
        check("R9 serial ends", {6'd0, lo_msb, lo_lsb}, {6'd0, mdl_lo[W-1], mdl_lo[0]});
        @(posedge clk);
        dn_eff = casc ? mdl_hi[0] : dn;
        mdl_hi = next_val(mdl_hi, m, mdl_lo[W-1], dnhi, phi);
        mdl_lo = next_val(mdl_lo, m, up, dn_eff, plo);
        last_req = ((a | b) && m != 2'b11) ? {req, "/R10"} : req;
        @(negedge clk);
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h1f3a_77c1;
        void'($urandom(seed));
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset holds zero even with load mode and edges
        mode = 2'b11; drv_lo = 8'hC3; drv_hi = 8'h3C;
        @(negedge clk);
        mode = 2'b00; #1;
        check("R1 reset state lo", bus_lo, 8'h00);
        check("R1 reset state hi", bus_hi, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // directed R5 then R3 with ones entering, R4 with zeros entering
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h5A, "R5");
        for (int k = 0; k < W; k++) step(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R3");
        for (int k = 0; k < W; k++) step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R4");
        // R8 with enables low during load, R10 shifting with bus released
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h00, "R8");
        step(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
        step(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R2");

        // random, single-word operation
        for (int k = 0; k < 1500; k++) begin
            logic [1:0] m;
            m = 2'($urandom);
            step(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 8'($urandom), 8'($urandom), mode_req(m));
        end

        // cascade: two words shifting as one
        casc = 1'b1;
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h01, "R11");
        step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R11");
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, "R11");
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R11");
        for (int k = 0; k < 1500; k++) begin
            logic [1:0] m;
            m = 2'($urandom);
            step(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 8'($urandom), 8'($urandom), "R11");
        end
        casc = 1'b0;

        // R1 asynchronous: reset between edges clears at once
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, "R5");
        mode = 2'b00; oe_a = 1'b0; oe_b = 1'b0; oe_hi = 1'b0;
        #1;
        check("R5 load ones", bus_lo, 8'hFF);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async clear lo", bus_lo, 8'h00);
        check("R1 async clear serial", {6'd0, lo_msb, lo_lsb}, 8'h00);
        mode = 2'b01; s_up = 1'b1;
        @(posedge clk); @(negedge clk);
        mode = 2'b00; #1;
        check("R1 reset overrides shift", bus_lo, 8'h00);
        check("R1 reset overrides shift hi", bus_hi, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule